// File: doc/BRIEF.md
# Multiplexed 16-bit Controller Bus Slave

This block lets an external controller read and write a set of internal registers over a 16-bit bus. The same 16 lines carry first an address and then data. The controller drives the address while the address-latch strobe is high, and the slave captures bits 15:2 of it. Address bit 1 comes from a separate pin that is sampled at the access, and bit 0 is always zero. Only whole 16-bit words are transferred. Chip select is active low. The direction pin is high for a write and low for a read. The slave ends every cycle by pulling an active-low ready output low a fixed number of clocks after chip select is seen low. It releases ready once chip select returns high. It drives the data lines only during the data phase of a read.

Data can be exchanged in big-endian order, which is the default, or in little-endian order, where the two bytes of every word are swapped on the bus in both directions. A general-purpose register samples two input pins and drives one output pin. A rising edge on either input latches an interrupt, which pulls an open-drain request line low when it is enabled. A configuration bit starts a soft-reset sequence. A parameterised set of scratch words stands in for the rest of the internal registers.

The transaction state machine has four states. IDLE goes to WAIT when chip select is sampled low. WAIT goes back to IDLE if chip select rises (an abort), and goes on to ACCESS when the delay has run out. ACCESS always goes to READY. READY goes to IDLE when chip select is sampled high.

Register map (word offsets): 0x00 configuration (bit 0 little-endian, bit 1 soft reset, bit 2 interrupt enable), 0x02 interrupt status (bit 0 pending), 0x40 general-purpose register, 0x80 upward scratch words.

Top module: `mbus_slave`

## Requirements
- R1: After reset, rdy_n is 1, ad_oe is 0, irq_od_en is 0, gp_out is 0 and the configuration register reads 0x0000, which means big-endian order.
- R2: While ale is high, the slave captures AD[15:2] as the address. The word address used at the access is {captured AD[15:2], a1 pin, 0}, so AD[1:0] during the address phase have no effect.
- R3: rdy_n goes low exactly RDY_DELAY+2 clock edges after the first edge that samples cs_n low, stays low while cs_n stays low, and goes high at the first edge that samples cs_n high. If cs_n rises during WAIT, the cycle aborts without asserting ready and without writing anything.
- R4: ad_oe is 1 only while rdy_n is low in a read cycle with cs_n low, and ad_out then holds the read word. At all other times ad_oe is 0.
- R5: A write (wr_rd = 1) stores the full 16-bit word, and a later read of the same address returns it.
- R6: When configuration bit 0 is 0, the bus word equals the register word. When it is 1, the bytes are swapped in both directions. The setting in force at the access applies to that access.
- R7: Offset 0x40 reads {13'b0, gp_out, gp_in} with gp_in passed through two synchronising flops. Bit 2 is read/write and drives gp_out. Writes to bits 1:0 and 15:3 are ignored.
- R8: Status bit 0 at offset 0x02 is set by a rising edge on either gp_in bit and cleared by writing 1 to it. When a set and a clear fall in the same cycle, the set wins. irq_od_en equals the pending bit AND configuration bit 2.
- R9: Writing 1 to configuration bit 1 starts a sequence lasting SRST_CYCLES clocks. From the same edge, all registers take their reset values. While the sequence runs, bit 1 reads 1 and writes are ignored. Afterwards bit 1 reads 0.
- R10: A read of an unmapped address returns 0x0000, and a write to one changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ale | input | 1 | Address latch strobe, high during the address phase |
| cs_n | input | 1 | Active-low chip select |
| wr_rd | input | 1 | Direction: 1 write, 0 read |
| a1 | input | 1 | Address bit 1 on its own pin |
| ad_in | input | 16 | Multiplexed address/data bus, input side |
| ad_out | output | 16 | Read data for the bus |
| ad_oe | output | 1 | Bus output enable (1 = drive AD) |
| rdy_n | output | 1 | Active-low cycle-termination ready |
| irq_od_en | output | 1 | 1 = pull the open-drain interrupt line low |
| gp_in | input | 2 | General-purpose input pins |
| gp_out | output | 1 | General-purpose output pin |

## Verification
Two functions can act on the pending bit in the same clock: a clearing write from the bus, and a set from a synchronised rising edge on gp_in. The bench times the gp_in change inside the clearing write, RDY_DELAY-1 edges after chip select falls. This places the set in the same edge as the write, given the three-flop path from pin to pending bit. The collision is judged by the interrupt line remaining pulled and the status word reading 1 afterwards. A second overlap is also checked: the soft-reset start clears every register at the same edge that carries its own configuration write.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_ACCESS,
        ST_READY
    } bus_state_t;

    localparam logic [15:0] OFS_CFG      = 16'h0000;
    localparam logic [15:0] OFS_IRQ      = 16'h0002;
    localparam logic [15:0] OFS_GPIO     = 16'h0040;
    localparam logic [15:0] OFS_SCR_BASE = 16'h0080;

    localparam int CFG_LE_BIT   = 0;
    localparam int CFG_SRST_BIT = 1;
    localparam int CFG_IEN_BIT  = 2;

    function automatic logic [15:0] swap_bytes(input logic [15:0] w);
        return {w[7:0], w[15:8]};
    endfunction

endpackage

// File: rtl/mbus_bus_fsm.sv
module mbus_bus_fsm
    import mbus_pkg::*;
#(
    parameter int RDY_DELAY = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    output bus_state_t state,
    output logic       access_stb,
    output logic       rdy_n
);

    localparam int CW = (RDY_DELAY > 1) ? $clog2(RDY_DELAY + 1) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(RDY_DELAY - 1);

    bus_state_t    state_nx;
    logic [CW-1:0] wait_cnt;

    // state register and wait counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            wait_cnt <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_WAIT)
                wait_cnt <= wait_cnt + 1'b1;
            else
                wait_cnt <= '0;
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (!cs_n) state_nx = ST_WAIT;
            ST_WAIT: begin
                if (cs_n)
                    state_nx = ST_IDLE;
                else if (wait_cnt == CNT_LAST)
                    state_nx = ST_ACCESS;
            end
            ST_ACCESS: state_nx = ST_READY;
            ST_READY:  if (cs_n) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        access_stb = (state == ST_ACCESS);
        rdy_n      = (state != ST_READY);
    end

endmodule

// File: rtl/mbus_srst_seq.sv
module mbus_srst_seq #(
    parameter int SRST_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    localparam int CW = $clog2(SRST_CYCLES + 1);
    localparam logic [CW-1:0] CNT_LOAD = CW'(SRST_CYCLES);

    logic [CW-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            remain <= '0;
        else if (start && remain == '0)
            remain <= CNT_LOAD;
        else if (remain != '0)
            remain <= remain - 1'b1;
    end

    assign busy = (remain != '0);

endmodule

// File: rtl/mbus_regfile.sv
module mbus_regfile
    import mbus_pkg::*;
#(
    parameter int N_SCRATCH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [15:0] addr,
    input  logic [15:0] wdata,
    input  logic [1:0]  gp_in,
    input  logic        srst_busy,
    output logic        srst_start,
    output logic [15:0] rdata,
    output logic        le,
    output logic        irq_od_en,
    output logic        gp_out
);

    localparam int SCR_W = (N_SCRATCH > 1) ? $clog2(N_SCRATCH) : 1;
    localparam logic [15:0] SCR_END = OFS_SCR_BASE + 16'(2 * N_SCRATCH);

    logic                    ien_q;
    logic                    pend_q;
    logic [1:0]              gp_s1, gp_s2, gp_prev;
    logic                    gp_rise;
    logic                    wr_ok;
    logic                    clr_all;
    logic                    scr_hit;
    logic [15:0]             scr_off;
    logic [SCR_W-1:0]        scr_idx;
    logic [16*N_SCRATCH-1:0] scr_flat;
    logic                    unused_scr_off;

    assign wr_ok      = wr_en && !srst_busy;
    assign srst_start = wr_ok && (addr == OFS_CFG) && wdata[CFG_SRST_BIT];
    assign clr_all    = srst_busy || srst_start;

    assign scr_hit = (addr >= OFS_SCR_BASE) && (addr < SCR_END);
    assign scr_off = addr - OFS_SCR_BASE;
    assign scr_idx = scr_off[SCR_W:1];
    assign unused_scr_off = ^{scr_off[15:SCR_W+1], scr_off[0]};

    // input synchronisers and edge history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gp_s1   <= '0;
            gp_s2   <= '0;
            gp_prev <= '0;
        end else begin
            gp_s1   <= gp_in;
            gp_s2   <= gp_s1;
            gp_prev <= gp_s2;
        end
    end

    assign gp_rise = |(gp_s2 & ~gp_prev);

    // configuration, output and interrupt state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            le     <= 1'b0;
            ien_q  <= 1'b0;
            gp_out <= 1'b0;
            pend_q <= 1'b0;
        end else if (clr_all) begin
            le     <= 1'b0;
            ien_q  <= 1'b0;
            gp_out <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            if (wr_ok && addr == OFS_CFG) begin
                le    <= wdata[CFG_LE_BIT];
                ien_q <= wdata[CFG_IEN_BIT];
            end
            if (wr_ok && addr == OFS_GPIO)
                gp_out <= wdata[2];
            if (gp_rise)
                pend_q <= 1'b1;
            else if (wr_ok && addr == OFS_IRQ && wdata[0])
                pend_q <= 1'b0;
        end
    end

    // scratch words
    for (genvar i = 0; i < N_SCRATCH; i++) begin : g_scr
        logic [15:0] word_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                word_q <= '0;
            else if (clr_all)
                word_q <= '0;
            else if (wr_ok && scr_hit && scr_idx == SCR_W'(i))
                word_q <= wdata;
        end
        assign scr_flat[16*i +: 16] = word_q;
    end

    // read multiplexer
    always_comb begin
        rdata = '0;
        if (addr == OFS_CFG)
            rdata = {13'b0, ien_q, srst_busy, le};
        else if (addr == OFS_IRQ)
            rdata = {15'b0, pend_q};
        else if (addr == OFS_GPIO)
            rdata = {13'b0, gp_out, gp_s2};
        else if (scr_hit)
            rdata = scr_flat[16*scr_idx +: 16];
    end

    assign irq_od_en = pend_q && ien_q;

endmodule

// File: rtl/mbus_slave.sv
module mbus_slave
    import mbus_pkg::*;
#(
    parameter int RDY_DELAY   = 2,
    parameter int N_SCRATCH   = 8,
    parameter int SRST_CYCLES = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ale,
    input  logic        cs_n,
    input  logic        wr_rd,
    input  logic        a1,
    input  logic [15:0] ad_in,
    output logic [15:0] ad_out,
    output logic        ad_oe,
    output logic        rdy_n,
    output logic        irq_od_en,
    input  logic [1:0]  gp_in,
    output logic        gp_out
);

    bus_state_t  state;
    logic        access_stb;
    logic [13:0] addr_hi;
    logic [15:0] acc_addr;
    logic [15:0] wdata_int;
    logic [15:0] rdata_int;
    logic [15:0] rd_q;
    logic        is_read_q;
    logic        le;
    logic        wr_en;
    logic        srst_start;
    logic        srst_busy;
    logic        unused_addr_lsb;

    mbus_bus_fsm #(.RDY_DELAY(RDY_DELAY)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .state      (state),
        .access_stb (access_stb),
        .rdy_n      (rdy_n)
    );

    mbus_srst_seq #(.SRST_CYCLES(SRST_CYCLES)) u_srst (
        .clk   (clk),
        .rst_n (rst_n),
        .start (srst_start),
        .busy  (srst_busy)
    );

    mbus_regfile #(.N_SCRATCH(N_SCRATCH)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .addr       (acc_addr),
        .wdata      (wdata_int),
        .gp_in      (gp_in),
        .srst_busy  (srst_busy),
        .srst_start (srst_start),
        .rdata      (rdata_int),
        .le         (le),
        .irq_od_en  (irq_od_en),
        .gp_out     (gp_out)
    );

    // address phase capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            addr_hi <= '0;
        else if (ale)
            addr_hi <= ad_in[15:2];
    end

    assign unused_addr_lsb = ^ad_in[1:0];
    assign acc_addr  = {addr_hi, a1, 1'b0};
    assign wdata_int = le ? swap_bytes(ad_in) : ad_in;
    assign wr_en     = access_stb && wr_rd;

    // read data capture at the access
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q      <= '0;
            is_read_q <= 1'b0;
        end else if (access_stb) begin
            is_read_q <= !wr_rd;
            if (!wr_rd)
                rd_q <= le ? swap_bytes(rdata_int) : rdata_int;
        end
    end

    assign ad_out = rd_q;
    assign ad_oe  = (state == ST_READY) && is_read_q && !cs_n;

endmodule

// File: rtl/mbus_slave_chk.sv
module mbus_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic rdy_n,
    input logic ad_oe,
    input logic irq_od_en,
    input logic gp_out,
    input logic srst_busy
);

    assert_rdy_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy_n && cs_n) |=> rdy_n);

    assert_rdy_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy_n && !cs_n) |=> !rdy_n);

    assert_rdy_after_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy_n) |-> ($past(!cs_n, 1) && $past(!cs_n, 2)));

    assert_drive_only_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |-> (!cs_n && !rdy_n));

    assert_srst_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        srst_busy |-> (!irq_od_en && !gp_out));

endmodule

bind mbus_slave mbus_slave_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .rdy_n     (rdy_n),
    .ad_oe     (ad_oe),
    .irq_od_en (irq_od_en),
    .gp_out    (gp_out),
    .srst_busy (srst_busy)
);

// File: tb/mbus_slave_bench.sv
module mbus_slave_bench;

    localparam int RDY_DELAY = 2;
    localparam int LAT       = RDY_DELAY + 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ale = 1'b0;
    logic        cs_n = 1'b1;
    logic        wr_rd = 1'b0;
    logic        a1 = 1'b0;
    logic [15:0] ad_in = 16'h0;
    logic [1:0]  gp_in = 2'b00;
    logic [15:0] ad_out;
    logic        ad_oe;
    logic        rdy_n;
    logic        irq_od_en;
    logic        gp_out;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    mbus_slave #(.RDY_DELAY(RDY_DELAY), .N_SCRATCH(8), .SRST_CYCLES(64)) u_mbus_slave (
        .clk(clk), .rst_n(rst_n), .ale(ale), .cs_n(cs_n), .wr_rd(wr_rd), .a1(a1),
        .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .rdy_n(rdy_n),
        .irq_od_en(irq_od_en), .gp_in(gp_in), .gp_out(gp_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // cycle-by-cycle reference for ready and bus drive (R3, R4)
    int   low_edges = 0;
    logic exp_rdy_n = 1'b1;

    always @(posedge clk) begin
        if (!rst_n || cs_n) begin
            low_edges = 0;
            exp_rdy_n = 1'b1;
        end else begin
            low_edges = low_edges + 1;
            exp_rdy_n = (low_edges >= LAT) ? 1'b0 : 1'b1;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            check("R3 per-cycle rdy_n", rdy_n, exp_rdy_n);
            check("R4 per-cycle ad_oe", ad_oe, !exp_rdy_n && !cs_n && !wr_rd);
        end
    end

    task automatic bus(input logic wr, input logic [15:0] abus, input logic a1v,
                       input logic [15:0] wbus, output logic [15:0] rbus,
                       input int gp_at, input logic [1:0] gp_val);
        int n;
        @(negedge clk);
        ale = 1'b1; ad_in = abus; a1 = a1v;
        @(negedge clk);
        ale = 1'b0; ad_in = wr ? wbus : 16'h0; wr_rd = wr; cs_n = 1'b0;
        if (gp_at == 0) gp_in = gp_val;
        n = 0;
        while (rdy_n === 1'b1 && n < 40) begin
            @(negedge clk);
            n++;
            if (n == gp_at) gp_in = gp_val;
        end
        check("R3 ready latency", n, LAT);
        rbus = ad_out;
        if (!wr) check("R4 drive in read", ad_oe, 1'b1);
        cs_n = 1'b1; wr_rd = 1'b0;
        @(negedge clk);
        check("R3 release", rdy_n, 1'b1);
    endtask

    task automatic wr(input logic [15:0] addr, input logic [15:0] data);
        logic [15:0] d;
        bus(1'b1, addr, addr[1], data, d, -1, 2'b00);
    endtask

    task automatic rd_chk(input string tag, input logic [15:0] addr, input logic [15:0] exp);
        logic [15:0] d;
        bus(1'b0, addr, addr[1], 16'h0, d, -1, 2'b00);
        check(tag, d, exp);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 rdy_n", rdy_n, 1'b1);
        check("R1 ad_oe", ad_oe, 1'b0);
        check("R1 irq", irq_od_en, 1'b0);
        check("R1 gp_out", gp_out, 1'b0);
        rd_chk("R1 cfg big-endian", 16'h0000, 16'h0000);

        // R5 word write and read back
        wr(16'h0080, 16'hA55A);
        wr(16'h008E, 16'h1234);
        rd_chk("R5 scratch0", 16'h0080, 16'hA55A);
        rd_chk("R5 scratch7", 16'h008E, 16'h1234);

        // R2 address bit 1 from its own pin, AD[1:0] ignored
        bus(1'b1, 16'h0083, 1'b0, 16'hBEEF, d, -1, 2'b00);
        rd_chk("R2 low word written", 16'h0080, 16'hBEEF);
        rd_chk("R2 odd word untouched", 16'h0082, 16'h0000);

        // R6 byte order
        wr(16'h0000, 16'h0001);
        rd_chk("R6 swapped read", 16'h0080, 16'hEFBE);
        rd_chk("R6 cfg in LE", 16'h0000, 16'h0100);
        wr(16'h0084, 16'h3412);
        wr(16'h0000, 16'h0000);
        rd_chk("R6 swapped write", 16'h0084, 16'h1234);

        // R3 abort during WAIT: no ready, no write
        @(negedge clk);
        ale = 1'b1; ad_in = 16'h0080; a1 = 1'b0;
        @(negedge clk);
        ale = 1'b0; ad_in = 16'h1111; wr_rd = 1'b1; cs_n = 1'b0;
        @(negedge clk);
        check("R3 abort no ready", rdy_n, 1'b1);
        cs_n = 1'b1; wr_rd = 1'b0;
        repeat (3) @(negedge clk);
        check("R3 abort stays idle", rdy_n, 1'b1);
        rd_chk("R3 abort no write", 16'h0080, 16'hBEEF);

        // R7 general-purpose register
        gp_in = 2'b10;
        repeat (4) @(negedge clk);
        rd_chk("R7 inputs", 16'h0040, 16'h0002);
        wr(16'h0040, 16'hFFFF);
        check("R7 gp_out set", gp_out, 1'b1);
        rd_chk("R7 reserved zero", 16'h0040, 16'h0006);

        // R8 interrupt
        rd_chk("R8 pending from rise", 16'h0002, 16'h0001);
        check("R8 masked", irq_od_en, 1'b0);
        wr(16'h0000, 16'h0004);
        check("R8 enabled irq", irq_od_en, 1'b1);
        wr(16'h0002, 16'h0001);
        check("R8 cleared irq", irq_od_en, 1'b0);
        rd_chk("R8 status cleared", 16'h0002, 16'h0000);
        gp_in = 2'b00;
        repeat (5) @(negedge clk);
        check("R8 fall ignored", irq_od_en, 1'b0);
        bus(1'b1, 16'h0002, 1'b1, 16'h0001, d, RDY_DELAY - 1, 2'b01);
        rd_chk("R8 set wins over clear", 16'h0002, 16'h0001);
        check("R8 irq after collision", irq_od_en, 1'b1);
        wr(16'h0002, 16'h0001);
        check("R8 plain clear", irq_od_en, 1'b0);

        // R9 soft reset
        wr(16'h0000, 16'h0005);
        wr(16'h0080, 16'h7777);
        wr(16'h0040, 16'h0400);
        check("R9 gp_out before", gp_out, 1'b1);
        gp_in = 2'b11;
        repeat (5) @(negedge clk);
        check("R9 irq before", irq_od_en, 1'b1);
        wr(16'h0000, 16'h0200);
        check("R9 gp_out cleared", gp_out, 1'b0);
        check("R9 irq cleared", irq_od_en, 1'b0);
        rd_chk("R9 busy big-endian", 16'h0000, 16'h0002);
        wr(16'h0084, 16'h5555);
        repeat (80) @(negedge clk);
        rd_chk("R9 done", 16'h0000, 16'h0000);
        rd_chk("R9 scratch0 cleared", 16'h0080, 16'h0000);
        rd_chk("R9 write ignored while busy", 16'h0084, 16'h0000);
        rd_chk("R9 gp after", 16'h0040, 16'h0003);

        // R10 unmapped addresses
        wr(16'h0080, 16'h4242);
        wr(16'h1234, 16'hFFFF);
        rd_chk("R10 unmapped read", 16'h1234, 16'h0000);
        rd_chk("R10 gap read", 16'h0004, 16'h0000);
        rd_chk("R10 scratch kept", 16'h0080, 16'h4242);
        rd_chk("R10 cfg kept", 16'h0000, 16'h0000);

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule